// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit translates an 11-bit virtual byte address into a physical address through a small table. Each table entry holds a base and a bounds value for one segment. The 2000-byte virtual space is cut into four fixed windows of 500 bytes. The window an address falls into selects the segment, and the distance from the window start is the offset. In user mode the offset is compared with the segment's bounds. If the offset fits, the physical address is the base plus the offset. If it does not fit, the unit flags a trap.

In kernel mode translation is skipped, and the physical address equals the virtual address. The same kernel flag guards a write port that loads base or bounds values into the table. A write attempted in user mode changes nothing and raises a trap. Every request and every write produces one registered response on the next clock. The response carries a valid flag, a trap flag and a physical address, and the address is forced to zero whenever the trap flag is set.

Top module: `seg_xlate`

## Requirements
- R1: A user request selects segment k when 500*k <= VA < 500*(k+1), for k = 0..3. The offset is VA - 500*k.
- R2: An accepted user request returns base[k] + offset, truncated to 12 bits. After reset, base/bounds are: segment 0 1000/400, segment 1 0/500, segment 2 600/300, segment 3 1500/400. So VA 0 gives 1000, VA 920 gives 420, VA 1040 gives 640 and VA 1898 gives 1898.
- R3: A user request whose offset is greater than or equal to bounds[k] traps. For example, VA 1900 traps.
- R4: A user request with VA >= 2000 traps.
- R5: A kernel request (req_kern_i = 1) returns the physical address equal to the VA, zero-extended, and never traps, even for VA >= 2000.
- R6: A kernel write sets an entry of the table. wr_seg_i selects the segment, and wr_fld_i selects the field: 0 is the base, loaded from wr_data_i; 1 is the bounds, loaded from wr_data_i[8:0]. The new value applies to requests from the next cycle on.
- R7: A write with req_kern_i = 0 leaves the table unchanged and gives a response with the trap flag set.
- R8: rsp_valid_o is high exactly one cycle after a cycle with req_valid_i or wr_en_i high, and low otherwise. rsp_trap_o and rsp_paddr_o belong to that same cycle.
- R9: Whenever rsp_trap_o is high, rsp_paddr_o is 0. A response to a write alone also has rsp_paddr_o 0.
- R10: While reset is held, all outputs are 0.
- R11: A request and a write in the same cycle share the privilege flag. In user mode the response traps with address 0, whatever the VA. In kernel mode the response is the bypass result, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 11 | Virtual byte address |
| req_kern_i | input | 1 | Kernel privilege for the request and the write |
| wr_en_i | input | 1 | Table write strobe |
| wr_fld_i | input | 1 | 0 = base, 1 = bounds |
| wr_seg_i | input | 2 | Segment to write |
| wr_data_i | input | 12 | Write value |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 12 | Physical address, 0 on trap |
| rsp_trap_o | output | 1 | Trap flag |

## Verification
A translation and a table write can arrive in the same cycle. In user mode the result must show the write's privilege trap even when the address itself would translate cleanly. In kernel mode the bypass result must be returned while the written value is put in place for later use. The bench drives both kinds of same-cycle pair. After the kernel pair it issues a user request to the rewritten segment, to confirm that the write took effect only afterwards. Around these cases, full sweeps of every virtual address in both privilege modes, against the reset table and against a rewritten table, compare each response with arithmetic done in the bench.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic {FLD_BASE = 1'b0, FLD_LIMIT = 1'b1} fld_e;

  function automatic int unsigned rst_base(input int unsigned i);
    case (i)
      0:       return 1000;
      1:       return 0;
      2:       return 600;
      3:       return 1500;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned rst_limit(input int unsigned i);
    case (i)
      0:       return 400;
      1:       return 500;
      2:       return 300;
      3:       return 400;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/seg_decode.sv
module seg_decode #(
  parameter int unsigned VA_W    = 11,
  parameter int unsigned SEG_CNT = 4,
  parameter int unsigned SPAN    = 500,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned OFF_W   = 9
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o,
  output logic             oor_o
);

  int unsigned cnt;
  logic [31:0] va_w;

  // window index = number of inner boundaries at or below va
  always_comb begin
    va_w = 32'(va_i);
    cnt  = 0;
    for (int unsigned k = 1; k < SEG_CNT; k++) begin
      if (va_w >= k * SPAN) cnt = cnt + 1;
    end
    idx_o = IDX_W'(cnt);
    off_o = OFF_W'(va_w - cnt * SPAN);
    oor_o = va_w >= SEG_CNT * SPAN;
  end

endmodule

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_CNT = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned PA_W    = 12,
  parameter int unsigned LIM_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             fld_i,
  input  logic [IDX_W-1:0] seg_i,
  input  logic [PA_W-1:0]  data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  base_o,
  output logic [LIM_W-1:0] limit_o
);

  logic [PA_W-1:0]  base_q [SEG_CNT];
  logic [LIM_W-1:0] lim_q  [SEG_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < SEG_CNT; i++) begin
        base_q[i] <= PA_W'(rst_base(i));
        lim_q[i]  <= LIM_W'(rst_limit(i));
      end
    end else if (we_i) begin
      if (fld_e'(fld_i) == FLD_LIMIT) lim_q[seg_i] <= data_i[LIM_W-1:0];
      else                            base_q[seg_i] <= data_i;
    end
  end

  assign base_o  = base_q[rd_idx_i];
  assign limit_o = lim_q[rd_idx_i];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_hold
    // R7
    tbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && seg_i == IDX_W'(g)) |=> ($stable(base_q[g]) && $stable(lim_q[g])));
  end

endmodule

// File: rtl/seg_xlate_core.sv
module seg_xlate_core #(
  parameter int unsigned VA_W  = 11,
  parameter int unsigned PA_W  = 12,
  parameter int unsigned OFF_W = 9,
  parameter int unsigned LIM_W = 9
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             kern_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             oor_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             fault_o
);

  logic over;

  assign over    = 32'(off_i) >= 32'(limit_i);
  assign fault_o = !kern_i && (oor_i || over);
  assign paddr_o = kern_i ? PA_W'(va_i) : base_i + PA_W'(off_i);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int unsigned VA_W    = 11,
  parameter int unsigned PA_W    = 12,
  parameter int unsigned SEG_CNT = 4,
  parameter int unsigned SPAN    = 500
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [VA_W-1:0]            req_vaddr_i,
  input  logic                       req_kern_i,
  input  logic                       wr_en_i,
  input  logic                       wr_fld_i,
  input  logic [$clog2(SEG_CNT)-1:0] wr_seg_i,
  input  logic [PA_W-1:0]            wr_data_i,
  output logic                       rsp_valid_o,
  output logic [PA_W-1:0]            rsp_paddr_o,
  output logic                       rsp_trap_o
);

  localparam int unsigned IDX_W  = $clog2(SEG_CNT);
  localparam int unsigned OFF_W  = $clog2(SPAN);
  localparam int unsigned LIM_W  = $clog2(SPAN + 1);
  localparam int unsigned VA_TOP = SEG_CNT * SPAN;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic             oor;
  logic [PA_W-1:0]  base;
  logic [LIM_W-1:0] limit;
  logic [PA_W-1:0]  paddr;
  logic             fault;
  logic             trap_d;
  logic [PA_W-1:0]  paddr_d;

  seg_decode #(.VA_W(VA_W), .SEG_CNT(SEG_CNT), .SPAN(SPAN), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dec (
    .va_i (req_vaddr_i),
    .idx_o(idx),
    .off_o(off),
    .oor_o(oor)
  );

  seg_table #(.SEG_CNT(SEG_CNT), .IDX_W(IDX_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && req_kern_i),
    .fld_i   (wr_fld_i),
    .seg_i   (wr_seg_i),
    .data_i  (wr_data_i),
    .rd_idx_i(idx),
    .base_o  (base),
    .limit_o (limit)
  );

  seg_xlate_core #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_core (
    .va_i   (req_vaddr_i),
    .kern_i (req_kern_i),
    .off_i  (off),
    .oor_i  (oor),
    .base_i (base),
    .limit_i(limit),
    .paddr_o(paddr),
    .fault_o(fault)
  );

  assign trap_d  = (req_valid_i && fault) || (wr_en_i && !req_kern_i);
  assign paddr_d = (req_valid_i && !trap_d) ? paddr : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_trap_o  <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i || wr_en_i;
      rsp_trap_o  <= trap_d;
      rsp_paddr_o <= paddr_d;
    end
  end

  // R8
  rsp_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i || wr_en_i) |=> rsp_valid_o);
  // R8
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i || wr_en_i) |=> !rsp_valid_o);
  // R9
  trap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_trap_o |-> (rsp_paddr_o == '0));
  // R5
  kern_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kern_i) |=> (!rsp_trap_o && rsp_paddr_o == PA_W'($past(req_vaddr_i))));
  // R4
  oor_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_kern_i && 32'(req_vaddr_i) >= VA_TOP) |=> rsp_trap_o);
  // R7
  user_wr_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !req_kern_i) |=> rsp_trap_o);

endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [10:0] req_vaddr = '0;
  logic        req_kern = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_fld = 1'b0;
  logic [1:0]  wr_seg = '0;
  logic [11:0] wr_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_trap;

  int checks = 0;
  int fails  = 0;
  int m_base [4] = '{1000, 0, 600, 1500};
  int m_lim  [4] = '{400, 500, 300, 400};

  always #2 clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_kern_i(req_kern),
    .wr_en_i(wr_en), .wr_fld_i(wr_fld), .wr_seg_i(wr_seg), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_trap_o(rsp_trap)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int va, input bit kern, output bit trap, output int pa);
    int seg, off;
    if (kern) begin trap = 0; pa = va; return; end
    if (va >= 2000) begin trap = 1; pa = 0; return; end
    seg = va / 500;
    off = va % 500;
    if (off >= m_lim[seg]) begin trap = 1; pa = 0; end
    else begin trap = 0; pa = (m_base[seg] + off) % 4096; end
  endfunction

  // one request cycle, called at a negedge; result checked at the next negedge
  task automatic req(input int va, input bit kern, input string tag);
    bit et; int ep;
    model(va, kern, et, ep);
    req_valid = 1; req_vaddr = 11'(va); req_kern = kern;
    @(negedge clk);
    req_valid = 0; req_kern = 0;
    chk(rsp_valid == 1'b1, {tag, " valid"}, rsp_valid, 1);
    chk(rsp_trap == et && int'(rsp_paddr) == ep, tag, rsp_trap ? -1 : int'(rsp_paddr), et ? -1 : ep);
  endtask

  task automatic wr(input int seg, input bit fld, input int data, input bit kern);
    wr_en = 1; wr_seg = 2'(seg); wr_fld = fld; wr_data = 12'(data); req_kern = kern;
    @(negedge clk);
    wr_en = 0; req_kern = 0;
    if (kern) begin
      if (fld) m_lim[seg] = data % 512; else m_base[seg] = data;
    end
    chk(rsp_valid && rsp_trap == !kern && rsp_paddr == 0, kern ? "R6 write rsp" : "R7 user write trap",
        {rsp_valid, rsp_trap}, {1'b1, !kern});
  endtask

  task automatic sweep(input bit kern, input string tag);
    for (int va = 0; va < 2048; va++) req(va, kern, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(rsp_valid == 0 && rsp_trap == 0 && rsp_paddr == 0, "R10 reset outputs",
        {rsp_valid, rsp_trap, rsp_paddr}, 0);
    rst_n = 1;
    @(negedge clk);
    // R8 idle
    chk(rsp_valid == 0, "R8 idle valid low", rsp_valid, 0);
    // R2 named points
    req(0, 0, "R2 va0");
    req(1040, 0, "R2 va1040");
    req(920, 0, "R2 va920");
    req(1898, 0, "R2 va1898");
    // R3 bounds edge
    req(1900, 0, "R3 va1900");
    req(399, 0, "R3 va399 last in");
    req(400, 0, "R3 va400 first out");
    // R4
    req(2000, 0, "R4 va2000");
    req(2047, 0, "R4 va2047");
    // R1 window edges
    req(499, 0, "R1 va499");
    req(500, 0, "R1 va500");
    req(1500, 0, "R1 va1500");
    @(negedge clk);
    chk(rsp_valid == 0, "R8 valid drops", rsp_valid, 0);
    // R1 R2 R3 R4 R9 full user sweep
    sweep(0, "R1 user sweep reset table");
    // R5 full kernel sweep
    sweep(1, "R5 kernel sweep");
    // R6 rewrite table, then immediate use
    wr(0, 0, 3000, 1);
    req(10, 0, "R6 new base next cycle");
    wr(0, 1, 100, 1);
    wr(1, 1, 0, 1);
    wr(2, 0, 0, 1);
    wr(2, 1, 500, 1);
    wr(3, 0, 3500, 1);
    wr(3, 1, 499, 1);
    sweep(0, "R6 user sweep new table");
    // R7 user writes ignored
    wr(2, 0, 1234, 0);
    wr(3, 1, 5, 0);
    sweep(0, "R7 table unchanged sweep");
    // R11 same-cycle user request + user write
    req_valid = 1; req_vaddr = 11'd600; req_kern = 0;
    wr_en = 1; wr_seg = 2'd1; wr_fld = 0; wr_data = 12'd77;
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    chk(rsp_valid && rsp_trap && rsp_paddr == 0, "R11 user pair traps", {rsp_trap, rsp_paddr}, {1'b1, 12'd0});
    req(1000, 0, "R11 table untouched by user pair");
    // R11 same-cycle kernel request + kernel write
    req_valid = 1; req_vaddr = 11'd1700; req_kern = 1;
    wr_en = 1; wr_seg = 2'd2; wr_fld = 0; wr_data = 12'd2222;
    @(negedge clk);
    req_valid = 0; wr_en = 0; req_kern = 0;
    m_base[2] = 2222;
    chk(rsp_valid && !rsp_trap && rsp_paddr == 1700, "R11 kernel pair bypass", rsp_paddr, 1700);
    req(1010, 0, "R11 kernel pair write applied");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule